// File: doc/BRIEF.md
# Serial Control-Frame Receiver

This block takes the serial line from a control-panel adapter and turns it into a register of 32 active-high input bits. The adapter sends a fixed six-byte packet each time an input changes. The packet opens with the header byte 0x05 and closes with the trailer byte 0x02. The four bytes in between carry the input states in negative logic.

The block contains a 16x oversampling 8N1 receiver and a frame parser. The parser hunts for the header and collects the four payload bytes into a shadow buffer. It updates the visible input register only when the trailer is correct. The host logic reads `inputs_o` directly. It watches the single-cycle `frame_ok_o` and `frame_err_o` pulses to learn when a packet was accepted or thrown away.

Top module: `ctrl_frame_rx`

## Requirements
- R1: After reset, `inputs_o` is all zero (every input released), `service_o` and `video_mode_o` are low, and neither pulse output is asserted.
- R2: The receiver decodes 8N1 characters, least significant bit first, at a bit time of 16 oversample ticks of `CLK_HZ/(16*BAUD)` clocks each. Each bit is taken as the majority of samples 7, 8 and 9 of its 16.
- R3: A low level on the idle line whose majority at mid-bit reads high is treated as a glitch. No character results from it.
- R4: The sequence 0x05, b1, b2, b3, b4, 0x02 sets `inputs_o` to `{~b4, ~b3, ~b2, ~b1}`, so payload byte n occupies bits [8n-1:8n-8]. `frame_ok_o` is high for exactly one clock.
- R5: `service_o` mirrors `inputs_o[26]` (payload byte 4, bit 2). `video_mode_o` mirrors `inputs_o[23]` (payload byte 3, bit 7).
- R6: If the sixth byte is not 0x02, `frame_err_o` pulses for one clock, `inputs_o` keeps its old value, and the parser returns to hunting. The next correct packet decodes normally.
- R7: While hunting, any byte other than 0x05 is ignored. No pulse is raised and `inputs_o` does not change.
- R8: Inside a packet, if more than `GAP_CLKS` clocks pass after a byte with no further byte, the packet is dropped silently. The remaining bytes are then treated as hunting input.
- R9: A character with a low stop bit inside a packet aborts the packet with a one-clock `frame_err_o` pulse and leaves `inputs_o` unchanged.
- R10: The packet 05 FC FF FF FF 02 gives `inputs_o` = 0x00000003, with only payload byte 1 bits 0 and 1 active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line from the adapter, idle high |
| inputs_o | output | 32 | Decoded inputs, active high; byte 1 in bits 7:0 |
| service_o | output | 1 | Service input, active high |
| video_mode_o | output | 1 | Video-mode input, active high |
| frame_ok_o | output | 1 | One-clock pulse when a packet is accepted |
| frame_err_o | output | 1 | One-clock pulse when a packet is rejected |

## Verification
A character is decided at the tenth sample of its stop bit. The sample passes through two synchronizer flops and one parser register, so the packet result appears about 10*OS_DIV+4 clocks into the stop bit, which is before that stop bit ends. The bench therefore checks each packet after the full stop bit plus eight idle clocks, sampling on the falling edge. It counts the clocks on which each pulse output is high, so a pulse that lasts longer than one clock or arrives twice changes the count and is reported. Random payloads, random inter-byte gaps and random corrupted trailers are mixed with directed cases for glitches, gap timeouts, bad stop bits and junk bytes while hunting.

// File: rtl/cfr_pkg.sv
package cfr_pkg;
    localparam logic [7:0] HDR_BYTE    = 8'h05;
    localparam logic [7:0] TRL_BYTE    = 8'h02;
    localparam int         PAY_BYTES   = 4;
    localparam int         OVERSAMPLE  = 16;
    localparam int         VOTE_FIRST  = 7;
    localparam int         VOTE_LAST   = 9;
    localparam int         SERVICE_BIT = 26;
    localparam int         VIDEO_BIT   = 23;

    typedef enum logic [1:0] {U_IDLE, U_START, U_DATA, U_STOP} urx_st_e;
    typedef enum logic [1:0] {P_HUNT, P_PAY, P_TAIL} prs_st_e;
endpackage

// File: rtl/cfr_uart_rx.sv
module cfr_uart_rx
    import cfr_pkg::*;
#(
    parameter int OS_DIV = 163
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_i,
    output logic [7:0] byte_o,
    output logic       byte_vld_o,
    output logic       stop_err_o
);
    localparam int DIV_W = (OS_DIV > 1) ? $clog2(OS_DIV) : 1;
    localparam int SMP_W = $clog2(OVERSAMPLE);

    typedef struct packed {
        logic             s1;
        logic             s2;
        logic [DIV_W-1:0] div;
        urx_st_e          st;
        logic [SMP_W-1:0] smp;
        logic [1:0]       ones;
        logic [2:0]       bitn;
        logic [7:0]       shift;
        logic             vld;
        logic             err;
    } urx_s;

    urx_s q, d;
    logic tick, bitv;
    logic [1:0] tot;

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        d.err = 1'b0;
        d.s1  = rx_i;
        d.s2  = q.s1;
        tick  = (q.div == DIV_W'(OS_DIV - 1));
        d.div = tick ? '0 : q.div + 1'b1;
        tot   = q.ones + {1'b0, q.s2};
        bitv  = tot[1];
        if (tick) begin
            if (q.st == U_IDLE) begin
                if (!q.s2) begin
                    d.st   = U_START;
                    d.smp  = SMP_W'(1);
                    d.ones = '0;
                end
            end else begin
                d.smp = q.smp + 1'b1;
                if (q.smp >= SMP_W'(VOTE_FIRST) && q.smp < SMP_W'(VOTE_LAST))
                    d.ones = tot;
                if (q.smp == SMP_W'(VOTE_LAST)) begin
                    unique case (q.st)
                        U_START: if (bitv) d.st = U_IDLE;
                        U_DATA:  d.shift = {bitv, q.shift[7:1]};
                        U_STOP: begin
                            d.st  = U_IDLE;
                            d.vld = bitv;
                            d.err = !bitv;
                        end
                        default: ;
                    endcase
                end
                if (q.smp == SMP_W'(OVERSAMPLE - 1)) begin
                    d.ones = '0;
                    if (q.st == U_START) begin
                        d.st   = U_DATA;
                        d.bitn = '0;
                    end else if (q.st == U_DATA) begin
                        if (q.bitn == 3'd7) d.st = U_STOP;
                        else                d.bitn = q.bitn + 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.s1    <= 1'b1;
            q.s2    <= 1'b1;
            q.st    <= U_IDLE;
        end else begin
            q <= d;
        end
    end

    assign byte_o     = q.shift;
    assign byte_vld_o = q.vld;
    assign stop_err_o = q.err;

    // R2
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({q.vld, q.err}));

    // R2
    strobe_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.vld || q.err) |-> ($past(q.st) == U_STOP));

    // R3
    glitch_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == U_START && tick && q.smp == SMP_W'(VOTE_LAST) && bitv) |=> (q.st == U_IDLE));
endmodule

// File: rtl/cfr_parser.sv
module cfr_parser
    import cfr_pkg::*;
#(
    parameter int GAP_CLKS = 100000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  byte_i,
    input  logic        byte_vld_i,
    input  logic        stop_err_i,
    output logic [31:0] inputs_o,
    output logic        ok_o,
    output logic        err_o
);
    localparam int GAP_W = $clog2(GAP_CLKS + 1);
    localparam int IDX_W = $clog2(PAY_BYTES);
    localparam int PAY_W = 8 * PAY_BYTES;

    typedef struct packed {
        prs_st_e          st;
        logic [IDX_W-1:0] idx;
        logic [PAY_W-1:0] shadow;
        logic [GAP_W-1:0] gap;
        logic [PAY_W-1:0] inputs;
        logic             ok;
        logic             err;
    } prs_s;

    prs_s q, d;

    always_comb begin
        d     = q;
        d.ok  = 1'b0;
        d.err = 1'b0;
        if (q.st == P_HUNT) begin
            if (byte_vld_i && byte_i == HDR_BYTE) begin
                d.st  = P_PAY;
                d.idx = '0;
                d.gap = '0;
            end
        end else if (stop_err_i) begin
            d.err = 1'b1;
            d.st  = P_HUNT;
        end else if (byte_vld_i) begin
            d.gap = '0;
            if (q.st == P_PAY) begin
                d.shadow[{q.idx, 3'b000} +: 8] = byte_i;
                if (q.idx == IDX_W'(PAY_BYTES - 1)) d.st  = P_TAIL;
                else                                 d.idx = q.idx + 1'b1;
            end else begin
                d.st = P_HUNT;
                if (byte_i == TRL_BYTE) begin
                    d.inputs = ~q.shadow;
                    d.ok     = 1'b1;
                end else begin
                    d.err = 1'b1;
                end
            end
        end else if (q.gap == GAP_W'(GAP_CLKS)) begin
            d.st = P_HUNT;
        end else begin
            d.gap = q.gap + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= P_HUNT;
        end else begin
            q <= d;
        end
    end

    assign inputs_o = q.inputs;
    assign ok_o     = q.ok;
    assign err_o    = q.err;

    // R4
    ok_after_trailer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.ok |-> $past(q.st == P_TAIL && byte_vld_i && byte_i == TRL_BYTE));

    // R6
    ok_err_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({q.ok, q.err}));

    // R7
    inputs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.inputs != $past(q.inputs)) |-> q.ok);

    // R8
    gap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.gap <= GAP_W'(GAP_CLKS));

    // R8
    gap_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != P_HUNT && q.gap == GAP_W'(GAP_CLKS) && !byte_vld_i && !stop_err_i)
        |=> (q.st == P_HUNT && !q.err));
endmodule

// File: rtl/ctrl_frame_rx.sv
module ctrl_frame_rx
    import cfr_pkg::*;
#(
    parameter int CLK_HZ   = 50000000,
    parameter int BAUD     = 19200,
    parameter int GAP_CLKS = 100000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_i,
    output logic [31:0] inputs_o,
    output logic        service_o,
    output logic        video_mode_o,
    output logic        frame_ok_o,
    output logic        frame_err_o
);
    localparam int DIV_RAW = (CLK_HZ + BAUD * (OVERSAMPLE / 2)) / (BAUD * OVERSAMPLE);
    localparam int OS_DIV  = (DIV_RAW < 1) ? 1 : DIV_RAW;

    logic [7:0] rx_byte;
    logic       rx_vld;
    logic       rx_stop_err;

    cfr_uart_rx #(.OS_DIV(OS_DIV)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_i       (rx_i),
        .byte_o     (rx_byte),
        .byte_vld_o (rx_vld),
        .stop_err_o (rx_stop_err)
    );

    cfr_parser #(.GAP_CLKS(GAP_CLKS)) u_prs (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_i     (rx_byte),
        .byte_vld_i (rx_vld),
        .stop_err_i (rx_stop_err),
        .inputs_o   (inputs_o),
        .ok_o       (frame_ok_o),
        .err_o      (frame_err_o)
    );

    assign service_o    = inputs_o[SERVICE_BIT];
    assign video_mode_o = inputs_o[VIDEO_BIT];

    // R5
    named_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (service_o == inputs_o[26]) && (video_mode_o == inputs_o[23]));
endmodule

// File: tb/tb_ctrl_frame_rx.sv
module tb_ctrl_frame_rx;
    localparam int CLK_HZ = 50000000;
    localparam int BAUD   = 1562500;
    localparam int GAP    = 800;
    localparam int BIT    = 32;
    localparam int WD     = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx = 1'b1;
    logic [31:0] inputs;
    logic        service, video, fok, ferr;

    int checks = 0, errors = 0, ok_seen = 0, err_seen = 0, cyc = 0;
    logic [31:0] exp_in = '0;

    always #10 clk = ~clk;

    ctrl_frame_rx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .GAP_CLKS(GAP)) dut (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .inputs_o(inputs),
        .service_o(service), .video_mode_o(video),
        .frame_ok_o(fok), .frame_err_o(ferr)
    );

    function automatic logic [31:0] decode(input logic [7:0] b1, b2, b3, b4);
        return ~{b4, b3, b2, b1};
    endfunction

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n && fok)  ok_seen++;
        if (rst_n && ferr) err_seen++;
        if (cyc > WD) begin
            errors++;
            $display("FAIL watchdog: actual cycles %0d expected below %0d", cyc, WD);
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int n);
        rx = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic stop_ok, input int idle);
        hold(1'b0, BIT);
        for (int i = 0; i < 8; i++) hold(b[i], BIT);
        hold(stop_ok, BIT);
        if (!stop_ok) hold(1'b1, 2 * BIT);
        hold(1'b1, idle);
    endtask

    task automatic send_frame(input logic [7:0] b1, b2, b3, b4, trl, input int idle);
        send_byte(8'h05, 1'b1, idle);
        send_byte(b1, 1'b1, idle);
        send_byte(b2, 1'b1, idle);
        send_byte(b3, 1'b1, idle);
        send_byte(b4, 1'b1, idle);
        send_byte(trl, 1'b1, 0);
    endtask

    task automatic expect_result(input string tag, input int d_ok, input int d_err,
                                 input int ok0, input int err0);
        hold(1'b1, 8);
        chk({tag, " ok pulses"}, 32'(ok_seen - ok0), 32'(d_ok));
        chk({tag, " err pulses"}, 32'(err_seen - err0), 32'(d_err));
        chk({tag, " inputs"}, inputs, exp_in);
    endtask

    initial begin
        int ok0, err0;
        logic [7:0] b1, b2, b3, b4, trl;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        // R1 reset state
        chk("R1 inputs", inputs, 32'h0);
        chk("R1 named", {30'd0, service, video}, 32'h0);
        chk("R1 pulses", {30'd0, fok, ferr}, 32'h0);
        rst_n = 1'b1;
        hold(1'b1, 20);

        // R10 and R4: documented example packet
        ok0 = ok_seen; err0 = err_seen;
        send_frame(8'hFC, 8'hFF, 8'hFF, 8'hFF, 8'h02, 0);
        exp_in = 32'h0000_0003;
        expect_result("R10", 1, 0, ok0, err0);

        // R5 named bits: byte4 bit2 low, byte3 bit7 low
        ok0 = ok_seen; err0 = err_seen;
        send_frame(8'hFF, 8'hFF, 8'h7F, 8'hFB, 8'h02, 5);
        exp_in = decode(8'hFF, 8'hFF, 8'h7F, 8'hFB);
        expect_result("R5", 1, 0, ok0, err0);
        chk("R5 service", {31'd0, service}, 32'd1);
        chk("R5 video", {31'd0, video}, 32'd1);

        // R6 wrong trailer keeps inputs
        ok0 = ok_seen; err0 = err_seen;
        send_frame(8'h00, 8'h00, 8'h00, 8'h00, 8'h03, 0);
        expect_result("R6", 0, 1, ok0, err0);

        // R7 junk while hunting
        ok0 = ok_seen; err0 = err_seen;
        send_byte(8'h33, 1'b1, 0);
        send_byte(8'h02, 1'b1, 0);
        send_byte(8'hFF, 1'b1, 0);
        expect_result("R7", 0, 0, ok0, err0);

        // R3 glitch inside a packet must not add a byte
        ok0 = ok_seen; err0 = err_seen;
        send_byte(8'h05, 1'b1, 10);
        hold(1'b0, 10);
        hold(1'b1, 60);
        send_byte(8'hA5, 1'b1, 0);
        send_byte(8'h5A, 1'b1, 0);
        send_byte(8'h0F, 1'b1, 0);
        send_byte(8'hF0, 1'b1, 0);
        send_byte(8'h02, 1'b1, 0);
        exp_in = decode(8'hA5, 8'h5A, 8'h0F, 8'hF0);
        expect_result("R3", 1, 0, ok0, err0);

        // R8 gap timeout drops packet silently
        ok0 = ok_seen; err0 = err_seen;
        send_byte(8'h05, 1'b1, 0);
        send_byte(8'h11, 1'b1, 2 * GAP);
        send_byte(8'h22, 1'b1, 0);
        send_byte(8'h33, 1'b1, 0);
        send_byte(8'h44, 1'b1, 0);
        send_byte(8'h02, 1'b1, 0);
        expect_result("R8", 0, 0, ok0, err0);

        // R9 bad stop bit aborts, then recovery
        ok0 = ok_seen; err0 = err_seen;
        send_byte(8'h05, 1'b1, 0);
        send_byte(8'hAA, 1'b0, 0);
        expect_result("R9", 0, 1, ok0, err0);
        ok0 = ok_seen; err0 = err_seen;
        send_frame(8'hFE, 8'hFD, 8'hFB, 8'hF7, 8'h02, 3);
        exp_in = decode(8'hFE, 8'hFD, 8'hFB, 8'hF7);
        expect_result("R9 recovery", 1, 0, ok0, err0);

        // R2 R4 R6 random packets
        for (int k = 0; k < 24; k++) begin
            b1 = 8'($urandom); b2 = 8'($urandom);
            b3 = 8'($urandom); b4 = 8'($urandom);
            trl = 8'h02;
            if (($urandom % 4) == 0) trl = 8'h02 ^ (8'h01 << ($urandom % 8));
            ok0 = ok_seen; err0 = err_seen;
            send_frame(b1, b2, b3, b4, trl, int'($urandom % 100));
            if (trl == 8'h02) begin
                exp_in = decode(b1, b2, b3, b4);
                expect_result("R4 random", 1, 0, ok0, err0);
            end else begin
                expect_result("R6 random", 0, 1, ok0, err0);
            end
            chk("R2 random service", {31'd0, service}, {31'd0, exp_in[26]});
            hold(1'b1, int'($urandom % 50));
        end

        summary();
        $finish;
    end
endmodule